// File: doc/BRIEF.md
# Timer Capture/Compare Channel Bank

This block sits beside a free-running 16-bit counter that is generated elsewhere and watches it on every clock. Four compare channels (C1 to C4) each hold a 16-bit value. When the counter equals that value, the channel raises a flag. Three of them (C2 to C4) can also move an output pin. A fifth register pair is shared. A mode input makes it either a fifth compare channel (C5, which also drives a pin) or a fourth capture channel (K4).

Three capture channels (K1 to K3), plus K4 when the shared pair is in capture mode, watch external pins. They do this through a two-stage synchronizer. On the selected edge they record the counter value.

Software reaches the block through a byte-wide register port. Each 16-bit value appears as a high/low byte pair. Two control bytes choose the pin action of each compare channel and the edge sensitivity of each capture channel. Sticky event flags and one interrupt line report matches and captures. A clear-pulse input acknowledges the flags.

Top module: `tmr_chan_bank`

## Requirements
- R1: After reset, the compare pairs and the shared pair read 0xFFFF. The capture pairs read 0x0000. Both control bytes read 0x00. All pins, all flags and the interrupt are 0.
- R2: Compare channel Cn (n=1..4) sits at byte offsets 0x16+2(n-1) for bits 15:8 and 0x17+2(n-1) for bits 7:0. The shared pair sits at 0x1E (high byte) and 0x1F (low byte). The action byte is at 0x20 and the edge byte at 0x21. A byte written to any of these offsets reads back unchanged, except that a write to the shared pair is dropped in capture mode (R6).
- R3: When the counter equals an enabled compare value, that channel's flag is set at the next clock edge. The flag sets whatever the channel's action code is. A counter value that differs from the compare value sets nothing.
- R4: Action byte fields are C2 in bits 7:6, C3 in 5:4, C4 in 3:2 and C5 in 1:0. The codes are: 00 leaves the pin alone, 01 inverts it, 10 drives it to 0, 11 drives it to 1. The pin changes at the clock edge that ends the match cycle, and holds when there is no match. oc_pin_o bit 0..3 is C2..C5.
- R5: With shared_cmp_i=1 the shared pair is compare channel C5. With shared_cmp_i=0 it is capture channel K4, and it then neither matches nor moves the C5 pin.
- R6: With shared_cmp_i=0, byte writes to offsets 0x1E/0x1F have no effect.
- R7: Edge byte fields are K4 in bits 7:6, K1 in 5:4, K2 in 3:2 and K3 in 1:0. The codes are: 00 never captures, 01 captures on a rising edge, 10 on a falling edge, 11 on either edge. cap_i bit 0..3 is K1..K4.
- R8: A qualifying input transition is registered by the third rising clock edge after it. At that edge the counter value is stored in the channel's register and the channel's flag is set. K1..K3 values read at 0x10/0x11, 0x12/0x13 and 0x14/0x15, high byte first. K4 values read through the shared pair. K4 never captures while shared_cmp_i=1.
- R9: flag_o bits 0..3 are C1..C4, bit 4 is the shared channel (C5 or K4), and bits 5..7 are K1..K3. A flag stays set until the matching bit of flag_clr_i is pulsed. irq_o is 1 exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_i | input | 16 | Free-running counter value |
| shared_cmp_i | input | 1 | 1: shared pair is compare C5; 0: capture K4 |
| cap_i | input | 4 | Capture pins K1..K4 (asynchronous) |
| addr_i | input | 6 | Register byte offset |
| wr_i | input | 1 | Byte write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| flag_clr_i | input | 8 | Flag clear pulses, one per flag |
| flag_o | output | 8 | Sticky event flags |
| irq_o | output | 1 | Any flag set |
| oc_pin_o | output | 4 | Compare output pins C2..C5 |

## Verification
Most internal state of this block is visible at the ports one clock after it changes:
- A wrong stored compare value shows as a missing or stray flag in the cycle after the counter passes the intended value.
- A wrong action field shows as a wrong pin level at that same point.
- A synchronizer or edge detector that is off by one stage shows as a flag rising one cycle early or late relative to the third edge after the input moves. The same fault leaves a wrong counter value in the capture pair.

The shared pair is the riskiest area, because a lockout fault is silent until the register is read back. The directed tests therefore read the pair back after blocked writes, and confirm that mode changes stop both its matching and its capturing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {ACT_NONE = 2'b00, ACT_TOG = 2'b01, ACT_LOW = 2'b10, ACT_HIGH = 2'b11} act_e;
  typedef enum logic [1:0] {EDG_OFF = 2'b00, EDG_RISE = 2'b01, EDG_FALL = 2'b10, EDG_ANY = 2'b11} edg_e;

  localparam logic [5:0] OFS_CAP_BASE = 6'h10;
  localparam logic [5:0] OFS_OC_BASE  = 6'h16;
  localparam logic [5:0] OFS_SHARED   = 6'h1E;
  localparam logic [5:0] OFS_ACT      = 6'h20;
  localparam logic [5:0] OFS_EDG      = 6'h21;

  // Pin level after a match under a given action code.
  function automatic logic pin_after(act_e a, logic cur);
    case (a)
      ACT_TOG:  return ~cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction

  // True when a prev->now transition qualifies under the edge code.
  function automatic logic edge_seen(edg_e e, logic prev, logic now);
    case (e)
      EDG_RISE: return !prev && now;
      EDG_FALL: return prev && !now;
      EDG_ANY:  return prev != now;
      default:  return 1'b0;
    endcase
  endfunction

  // Replace one byte of a 16-bit value.
  function automatic logic [15:0] put_byte(logic [15:0] old, logic hi, logic [7:0] d);
    return hi ? {d, old[7:0]} : {old[15:8], d};
  endfunction

  // Select one byte of a 16-bit value.
  function automatic logic [7:0] get_byte(logic [15:0] v, logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction
endpackage

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] ref_i,
  output logic         hit_o
);
  assign hit_o = en_i && (cnt_i == ref_i);
endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic [1:0] act_i,
  output logic       pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     pin_q <= 1'b0;
    else if (fire_i) pin_q <= pin_after(act_e'(act_i), pin_q);
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_cap_unit.sv
module tmr_cap_unit
  import tmr_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edg_i,
  output logic       hit_o
);
  logic [SYNC:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC-1:0], pin_i};
  end

  assign hit_o = edge_seen(edg_e'(edg_i), sh_q[SYNC], sh_q[SYNC-1]);
endmodule

// File: rtl/tmr_chan_bank.sv
module tmr_chan_bank
  import tmr_pkg::*;
#(
  parameter int N_OC = 4,
  parameter int N_IC = 3,
  parameter int SYNC = 2,
  localparam int CW  = 16,
  localparam int NP  = N_OC,
  localparam int NF  = N_OC + 1 + N_IC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          shared_cmp_i,
  input  logic [N_IC:0] cap_i,
  input  logic [5:0]    addr_i,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [NF-1:0] flag_clr_i,
  output logic [NF-1:0] flag_o,
  output logic          irq_o,
  output logic [NP-1:0] oc_pin_o
);
  logic [N_OC-1:0][CW-1:0] oc_q;
  logic [N_IC-1:0][CW-1:0] ic_q;
  logic [CW-1:0]           sh_q;
  logic [7:0]              act_q, edg_q;
  logic [NF-1:0]           flag_q;

  // Named internal events
  logic [N_OC:0]   cmp_hit;   // [N_OC-1:0] dedicated, [N_OC] shared compare
  logic [N_IC:0]   cap_hit;   // [N_IC-1:0] dedicated, [N_IC] shared capture
  logic [NF-1:0]   flag_set;
  logic            sh_wr_ok;

  assign sh_wr_ok = shared_cmp_i;

  // Compare units and their registers
  for (genvar i = 0; i < N_OC; i++) begin : g_oc
    localparam logic [5:0] AH = OFS_OC_BASE + 6'(2 * i);
    tmr_cmp_unit #(.W(CW)) u_cmp (
      .en_i(1'b1), .cnt_i(cnt_i), .ref_i(oc_q[i]), .hit_o(cmp_hit[i])
    );
    always_ff @(posedge clk_i) begin
      if (!rst_ni) oc_q[i] <= '1;
      else if (wr_i && addr_i[5:1] == AH[5:1])
        oc_q[i] <= put_byte(oc_q[i], ~addr_i[0], wdata_i);
    end
  end

  tmr_cmp_unit #(.W(CW)) u_cmp_sh (
    .en_i(shared_cmp_i), .cnt_i(cnt_i), .ref_i(sh_q), .hit_o(cmp_hit[N_OC])
  );

  // Pin controllers: pin p follows compare channel p+1
  for (genvar p = 0; p < NP; p++) begin : g_pin
    tmr_pin_ctl u_pin (
      .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(cmp_hit[p+1]),
      .act_i(act_q[7-2*p -: 2]), .pin_o(oc_pin_o[p])
    );
  end

  // Capture units: dedicated ones take edge fields after the shared one
  for (genvar j = 0; j < N_IC; j++) begin : g_ic
    localparam logic [5:0] AH = OFS_CAP_BASE + 6'(2 * j);
    tmr_cap_unit #(.SYNC(SYNC)) u_cap (
      .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_i[j]),
      .edg_i(edg_q[5-2*j -: 2]), .hit_o(cap_hit[j])
    );
    always_ff @(posedge clk_i) begin
      if (!rst_ni)         ic_q[j] <= '0;
      else if (cap_hit[j]) ic_q[j] <= cnt_i;
    end
  end

  tmr_cap_unit #(.SYNC(SYNC)) u_cap_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cap_i[N_IC]),
    .edg_i(shared_cmp_i ? 2'b00 : edg_q[7:6]), .hit_o(cap_hit[N_IC])
  );

  // Shared register: CPU-owned in compare mode, capture-owned otherwise
  always_ff @(posedge clk_i) begin
    if (!rst_ni) sh_q <= '1;
    else if (sh_wr_ok) begin
      if (wr_i && addr_i[5:1] == OFS_SHARED[5:1])
        sh_q <= put_byte(sh_q, ~addr_i[0], wdata_i);
    end else if (cap_hit[N_IC]) begin
      sh_q <= cnt_i;
    end
  end

  // Control bytes
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      act_q <= '0;
      edg_q <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_ACT) act_q <= wdata_i;
      if (addr_i == OFS_EDG) edg_q <= wdata_i;
    end
  end

  // Flags: set wins over clear
  assign flag_set = {cap_hit[N_IC-1:0], cmp_hit[N_OC] | cap_hit[N_IC], cmp_hit[N_OC-1:0]};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr_i) | flag_set;
  end

  assign flag_o = flag_q;
  assign irq_o  = |flag_q;

  // Read mux
  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < N_OC; i++)
      if (addr_i[5:1] == 5'((OFS_OC_BASE + 6'(2 * i)) >> 1))
        rdata_o = get_byte(oc_q[i], ~addr_i[0]);
    for (int j = 0; j < N_IC; j++)
      if (addr_i[5:1] == 5'((OFS_CAP_BASE + 6'(2 * j)) >> 1))
        rdata_o = get_byte(ic_q[j], ~addr_i[0]);
    if (addr_i[5:1] == OFS_SHARED[5:1]) rdata_o = get_byte(sh_q, ~addr_i[0]);
    if (addr_i == OFS_ACT) rdata_o = act_q;
    if (addr_i == OFS_EDG) rdata_o = edg_q;
  end
endmodule

// File: rtl/tmr_chan_bank_chk.sv
module tmr_chan_bank_chk #(
  parameter int N_OC = 4,
  parameter int N_IC = 3,
  parameter int NF   = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [15:0]             cnt_i,
  input logic                    shared_cmp_i,
  input logic [NF-1:0]           flag_clr_i,
  input logic [NF-1:0]           flag_o,
  input logic [N_OC-1:0]         oc_pin_o,
  input logic [N_OC:0]           cmp_hit,
  input logic [N_IC:0]           cap_hit,
  input logic [15:0]             sh_q,
  input logic [N_IC-1:0][15:0]   ic_q
);
  a_r3_flag_after_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmp_hit) |=> ((flag_o[N_OC:0] & $past(cmp_hit)) == $past(cmp_hit)));

  a_r4_pins_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_hit[N_OC:1] == '0) |=> $stable(oc_pin_o));

  a_r6_shared_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shared_cmp_i && !cap_hit[N_IC]) |=> $stable(sh_q));

  a_r8_capture_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit[0] |=> (ic_q[0] == $past(cnt_i)));

  a_r9_flags_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_o & ~flag_clr_i)) |=> ((flag_o & $past(flag_o & ~flag_clr_i)) == $past(flag_o & ~flag_clr_i)));
endmodule

bind tmr_chan_bank tmr_chan_bank_chk #(.N_OC(N_OC), .N_IC(N_IC), .NF(NF)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .shared_cmp_i(shared_cmp_i),
  .flag_clr_i(flag_clr_i), .flag_o(flag_o), .oc_pin_o(oc_pin_o),
  .cmp_hit(cmp_hit), .cap_hit(cap_hit), .sh_q(sh_q), .ic_q(ic_q)
);

// File: tb/tmr_chan_bank_tb.sv
`timescale 1ns/1ps
module tmr_chan_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h0000;
  logic        shared_cmp = 1'b0;
  logic [3:0]  cap = 4'h0;
  logic [5:0]  addr = 6'h00;
  logic        wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [7:0]  flag_clr = 8'h00;
  logic [7:0]  flags;
  logic        irq;
  logic [3:0]  pins;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_chan_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .shared_cmp_i(shared_cmp),
    .cap_i(cap), .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .flag_clr_i(flag_clr), .flag_o(flags), .irq_o(irq), .oc_pin_o(pins)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_b(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [5:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_cnt(input logic [15:0] v);
    @(negedge clk); cnt = v;
    @(negedge clk); cnt = 16'h0000;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 8'hFF;
    @(negedge clk); flag_clr = 8'h00;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 6'h16; a <= 6'h1F; a++) begin
      rd_b(6'(a), d); chk("R1 cmp/shared reset", d, 8'hFF);
    end
    rd_b(6'h10, d); chk("R1 capture reset", d, 8'h00);
    rd_b(6'h20, d); chk("R1 action reset", d, 8'h00);
    rd_b(6'h21, d); chk("R1 edge reset", d, 8'h00);
    chk("R1 pins reset", pins, 4'h0);
    chk("R1 flags reset", flags, 8'h00);
    chk("R1 irq reset", irq, 1'b0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr_b(6'h16, 8'h12); wr_b(6'h17, 8'h34);
    rd_b(6'h16, d); chk("R2 C1 high", d, 8'h12);
    rd_b(6'h17, d); chk("R2 C1 low", d, 8'h34);
    rd_b(6'h18, d); chk("R2 C2 untouched", d, 8'hFF);
  endtask

  task automatic t_compare();
    @(negedge clk); cnt = 16'h1233;
    cyc(1); chk("R3 no flag off-by-one", flags[0], 1'b0);
    cnt = 16'h1234;
    cyc(1); chk("R3 C1 flag on match", flags[0], 1'b1);
    chk("R9 irq follows flag", irq, 1'b1);
    chk("R3 C2 no flag", flags[1], 1'b0);
    cnt = 16'h0000;
    @(negedge clk); flag_clr = 8'h01;
    @(negedge clk); flag_clr = 8'h00;
    chk("R9 flag cleared", flags, 8'h00);
    chk("R9 irq cleared", irq, 1'b0);
  endtask

  task automatic t_actions();
    wr_b(6'h18, 8'h01); wr_b(6'h19, 8'h00);
    wr_b(6'h1A, 8'h01); wr_b(6'h1B, 8'h01);
    wr_b(6'h1C, 8'h01); wr_b(6'h1D, 8'h02);
    wr_b(6'h20, 8'h70);               // C2 toggle, C3 high, C4 none
    pulse_cnt(16'h0100); chk("R4 C2 toggle up", pins[0], 1'b1);
    pulse_cnt(16'h0100); chk("R4 C2 toggle down", pins[0], 1'b0);
    pulse_cnt(16'h0101); chk("R4 C3 drive high", pins[1], 1'b1);
    pulse_cnt(16'h0102); chk("R4 C4 none keeps pin", pins[2], 1'b0);
    chk("R3 flag with action none", flags[3], 1'b1);
    wr_b(6'h20, 8'h2C);               // C3 low, C4 high
    pulse_cnt(16'h0101); chk("R4 C3 drive low", pins[1], 1'b0);
    pulse_cnt(16'h0102); chk("R4 C4 drive high", pins[2], 1'b1);
    cyc(3); chk("R4 pin holds", pins[2], 1'b1);
    clear_flags();
  endtask

  task automatic t_shared();
    logic [7:0] d;
    @(negedge clk); shared_cmp = 1'b1;
    wr_b(6'h1E, 8'h02); wr_b(6'h1F, 8'h00);
    wr_b(6'h20, 8'h2F);               // C5 high
    pulse_cnt(16'h0200);
    chk("R5 C5 pin high", pins[3], 1'b1);
    chk("R5 C5 flag", flags[4], 1'b1);
    clear_flags();
    @(negedge clk); shared_cmp = 1'b0;
    wr_b(6'h1E, 8'hAB); wr_b(6'h1F, 8'hCD);
    rd_b(6'h1E, d); chk("R6 shared high locked", d, 8'h02);
    rd_b(6'h1F, d); chk("R6 shared low locked", d, 8'h00);
    wr_b(6'h20, 8'h2E);               // C5 low, but capture mode
    pulse_cnt(16'h0200);
    chk("R5 no C5 action in capture mode", pins[3], 1'b1);
    chk("R5 no C5 flag in capture mode", flags[4], 1'b0);
  endtask

  task automatic t_capture();
    logic [7:0] d;
    wr_b(6'h21, 8'hD8);               // K4 any, K1 rise, K2 fall, K3 off
    @(negedge clk); cnt = 16'h0ABC;
    @(negedge clk); cap[0] = 1'b1;
    cyc(2); chk("R8 K1 not before third edge", flags[5], 1'b0);
    cyc(1); chk("R8 K1 flag at third edge", flags[5], 1'b1);
    rd_b(6'h10, d); chk("R8 K1 high", d, 8'h0A);
    rd_b(6'h11, d); chk("R8 K1 low", d, 8'hBC);
    clear_flags();
    @(negedge clk); cnt = 16'h0DEF; cap[0] = 1'b0;
    cyc(4);
    rd_b(6'h10, d); chk("R7 K1 ignores fall", d, 8'h0A);
    chk("R7 K1 no flag on fall", flags[5], 1'b0);
    @(negedge clk); cap[1] = 1'b1;
    cyc(4); chk("R7 K2 ignores rise", flags[6], 1'b0);
    cap[1] = 1'b0;
    cyc(4); chk("R7 K2 flag on fall", flags[6], 1'b1);
    rd_b(6'h12, d); chk("R7 K2 high", d, 8'h0D);
    rd_b(6'h13, d); chk("R7 K2 low", d, 8'hEF);
    @(negedge clk); cap[2] = 1'b1;
    cyc(4); cap[2] = 1'b0;
    cyc(4); chk("R7 K3 disabled no flag", flags[7], 1'b0);
    rd_b(6'h15, d); chk("R7 K3 disabled no value", d, 8'h00);
    @(negedge clk); cnt = 16'h0777; cap[3] = 1'b1;
    cyc(4);
    rd_b(6'h1F, d); chk("R8 K4 rise capture", d, 8'h77);
    chk("R9 shared flag from K4", flags[4], 1'b1);
    @(negedge clk); cnt = 16'h0888; cap[3] = 1'b0;
    cyc(4);
    rd_b(6'h1E, d); chk("R7 K4 fall capture (any)", d, 8'h08);
    @(negedge clk); shared_cmp = 1'b1; cnt = 16'h0999; cap[3] = 1'b1;
    cyc(4);
    rd_b(6'h1E, d); chk("R8 K4 off in compare mode", d, 8'h08);
    @(negedge clk); shared_cmp = 1'b0; cnt = 16'h0000;
  endtask

  task automatic t_partial_clear();
    @(negedge clk); flag_clr = 8'h20;
    @(negedge clk); flag_clr = 8'h00;
    chk("R9 partial clear", flags, 8'h50);
    chk("R9 irq stays", irq, 1'b1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_map();
    t_compare();
    t_actions();
    t_shared();
    t_capture();
    t_partial_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule